// File: doc/BRIEF.md
# Dual-CAS DRAM Command Decoder

This block sits on the memory side of an asynchronous DRAM bus that has one row strobe and two byte column strobes. It samples the row strobe, the two column strobes, write enable, output enable and the shared address pins on a fast system clock, and it classifies what kind of memory cycle the bus master is running. From that it produces per-lane data-direction controls (drive read data, or accept write data), and it captures the row and column addresses. The classifications are standby, word and byte read and write, read-modify-write, extended-data-out page cycles, hidden refresh, row-only refresh and strobe-before-row refresh. The storage array is not part of this block. The outputs are meant to steer an array model or to act as a synthesizable protocol monitor.

An internal column strobe is active while either byte strobe is low. It therefore starts at the first byte strobe to fall and ends at the last one to rise. Each byte lane is steered by its own strobe. When the row strobe falls, the block checks whether a column strobe was already low and whether read data was being held, and picks the refresh kind from that edge order. For refresh cycles that have no external row, an internal counter supplies the row. Too-short strobe pulses are flagged.

All pin inputs pass through one register stage. `cycleType`, `laneDrive`, `laneWrite` and `protoErr` reflect the pins sampled at the previous rising clock edge. `rowAddr`, `colAddr` and `refreshCount` change one clock later than that.

Top module: `dram_cmd_decoder`

## Requirements
- R1: With the row strobe and both byte strobes sampled high and no held read, `cycleType` is 0 (standby), and `laneDrive` and `laneWrite` are both 00. This is also the state right after reset, and `refreshCount` is 0 after reset.
- R2: The internal column strobe is active from the first byte strobe to fall until the last one to rise. The column address is captured only at the first fall. A second byte strobe falling later captures nothing.
- R3: Read conditions are row strobe low, a byte strobe low, write enable high and output enable low. Under them `cycleType` is 2. Bit 0 of `laneDrive` follows the lower strobe (`lcasN` low) and bit 1 follows the upper strobe (`ucasN` low). Each bit is set only while its own strobe is low.
- R4: Write conditions are row strobe low, a byte strobe low and write enable low. Under them `cycleType` is 3, `laneWrite` has a 1 for each lane whose strobe is low (bit 0 lower, bit 1 upper), and `laneDrive` is 00. Output enable has no effect.
- R5: If the row strobe falls while at least one byte strobe is already low and no read is held, `cycleType` is 5 for the whole row-low period. `laneDrive` stays 00, and `rowAddr` shows the internal refresh counter.
- R6: If the row strobe falls with both byte strobes high, `cycleType` is 1 (row open) and the address is captured into `rowAddr`. If the row strobe then rises with no column strobe activity, `cycleType` is 7 (row-only refresh) for that one cycle.
- R7: Hidden refresh works as follows. After a read, the row strobe rises and falls again while a byte strobe stays low. The read lanes stay driven through the whole sequence, `cycleType` is 6 while the row strobe is low, and `rowAddr` shows the refresh counter.
- R8: In a read, write enable may fall inside the same column-strobe-low period. From then on `cycleType` is 4 (read-modify-write), `laneDrive` is 00, and `laneWrite` has a 1 for each strobed lane.
- R9: A row strobe low pulse shorter than `RAS_MIN_CYC` samples, or an internal column strobe low pulse shorter than `CAS_MIN_CYC` samples, raises `protoErr` for one cycle when the pulse ends. Pulses of legal length never raise it.
- R10: `refreshCount` rises by one at the end of every strobe-before-row refresh and every hidden refresh, and it wraps from 1023 to 0. A row-only refresh leaves it unchanged.
- R11: Page mode works as follows. Within one row-low period, each new fall of the internal column strobe captures a fresh column address, and each column period is classified again by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| lcasN | input | 1 | Lower byte column strobe, active low |
| ucasN | input | 1 | Upper byte column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address pins |
| cycleType | output | 3 | 0 standby, 1 row open, 2 read, 3 write, 4 read-modify-write, 5 strobe-before-row refresh, 6 hidden refresh, 7 row-only refresh |
| laneDrive | output | 2 | Per-lane read data drive enable (bit 0 lower, bit 1 upper) |
| laneWrite | output | 2 | Per-lane write enable (bit 0 lower, bit 1 upper) |
| rowAddr | output | ADDR_W | Captured row address, or the refresh counter during counter-based refresh |
| colAddr | output | ADDR_W | Captured column address |
| refreshCount | output | ADDR_W | Internal refresh row counter |
| protoErr | output | 1 | One-cycle pulse on a too-short strobe pulse |

## Verification
Hidden refresh is the hardest case to reach from the pins. It only exists when a read has just driven data, the row strobe rises while a byte strobe is held low, and then the row strobe falls again, all within one column-strobe-low period. The stimulus builds exactly this ordered sequence and checks that the lanes stay driven through both row edges. Counter wrap needs more than a thousand legal refresh cycles, so a loop of back-to-back strobe-before-row refreshes runs the counter to its last value before the directed wrap check. Random byte-lane read and write accesses with random addresses are mixed in between.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [2:0] {
    CT_STANDBY  = 3'd0,
    CT_ROW_OPEN = 3'd1,
    CT_READ     = 3'd2,
    CT_WRITE    = 3'd3,
    CT_RMW      = 3'd4,
    CT_CBR      = 3'd5,
    CT_HIDDEN   = 3'd6,
    CT_RAS_ONLY = 3'd7
  } cycle_t;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_ACCESS = 2'd1,
    M_CBR    = 2'd2,
    M_HIDDEN = 2'd3
  } mode_t;

  typedef struct packed {
    logic rowLatch;
    logic colLatch;
    logic refAdvance;
    logic useCounter;
  } strobe_t;

endpackage

// File: rtl/dcd_ctrl.sv
module dcd_ctrl
  import dcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic [1:0] casN,
  input  logic       weN,
  input  logic       oeN,
  output cycle_t     cycleType,
  output logic [1:0] laneDrive,
  output logic [1:0] laneWrite,
  output strobe_t    strobe,
  output logic [1:0] sampledLow
);

  logic       sRas, pRas, sWe, sOe, pCasAct;
  logic [1:0] sCas;
  mode_t      mode, modeNow, modeNext, fallMode;
  logic       afterAccess, colSeen, readSeen;
  logic       afterAccessNext, colSeenNext, readSeenNext;
  logic       casAct, rasLow, rasFell, rasRose, casFell;
  logic       ctx, readReq, accessLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sRas        <= 1'b1;
      pRas        <= 1'b1;
      sCas        <= 2'b11;
      pCasAct     <= 1'b0;
      sWe         <= 1'b1;
      sOe         <= 1'b1;
      mode        <= M_IDLE;
      afterAccess <= 1'b0;
      colSeen     <= 1'b0;
      readSeen    <= 1'b0;
    end else begin
      sRas        <= rasN;
      pRas        <= sRas;
      sCas        <= casN;
      pCasAct     <= casAct;
      sWe         <= weN;
      sOe         <= oeN;
      mode        <= modeNext;
      afterAccess <= afterAccessNext;
      colSeen     <= colSeenNext;
      readSeen    <= readSeenNext;
    end
  end

  // internal column strobe: first byte strobe down, last byte strobe up
  always_comb begin
    casAct  = ~(&sCas);
    rasLow  = ~sRas;
    rasFell = pRas & ~sRas;
    rasRose = ~pRas & sRas;
    casFell = casAct & ~pCasAct;
    readReq = sWe & ~sOe;
  end

  // edge order at the row strobe fall picks the cycle family
  always_comb begin
    if (!casAct)          fallMode = M_ACCESS;
    else if (afterAccess) fallMode = M_HIDDEN;
    else                  fallMode = M_CBR;
    modeNow  = rasFell ? fallMode : mode;
    modeNext = rasRose ? M_IDLE : modeNow;
  end

  always_comb begin
    accessLow = (modeNow == M_ACCESS) && rasLow;
    ctx       = (modeNow == M_ACCESS) || (modeNow == M_HIDDEN) || afterAccess;
    laneDrive = (ctx && readReq) ? ~sCas : 2'b00;
    laneWrite = (accessLow && !sWe) ? ~sCas : 2'b00;

    strobe.rowLatch   = rasFell & ~casAct;
    strobe.colLatch   = accessLow & casFell;
    strobe.refAdvance = rasRose & ((mode == M_CBR) || (mode == M_HIDDEN));
    strobe.useCounter = (modeNow == M_CBR) || (modeNow == M_HIDDEN);

    colSeenNext     = (rasFell ? 1'b0 : colSeen) | (accessLow & casAct);
    readSeenNext    = casAct & (readSeen | (accessLow & readReq));
    afterAccessNext = casAct & (afterAccess |
                      (rasRose & (mode == M_ACCESS) & readSeen & sWe));
    sampledLow      = {casAct, rasLow};
  end

  always_comb begin
    cycleType = CT_STANDBY;
    if (rasLow) begin
      case (modeNow)
        M_ACCESS: begin
          if (!casAct)     cycleType = CT_ROW_OPEN;
          else if (!sWe)   cycleType = readSeen ? CT_RMW : CT_WRITE;
          else if (!sOe)   cycleType = CT_READ;
          else             cycleType = CT_ROW_OPEN;
        end
        M_CBR:    cycleType = CT_CBR;
        M_HIDDEN: cycleType = CT_HIDDEN;
        default:  cycleType = CT_STANDBY;
      endcase
    end else if (rasRose && (mode == M_ACCESS) && !colSeen) begin
      cycleType = CT_RAS_ONLY;
    end else if (ctx && casAct && readReq) begin
      cycleType = CT_READ;
    end
  end

  // R1: all strobes high and nothing held means both lanes idle
  assert_standby_hiz_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sRas && (&sCas) && !afterAccess) |-> (laneDrive == 2'b00 && laneWrite == 2'b00));

  // R3: a lane is never driven and written at once
  assert_lane_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    (laneDrive & laneWrite) == 2'b00);

  // R5: refresh from the counter keeps the data pins quiet
  assert_cbr_hiz_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType == CT_CBR) |-> (laneDrive == 2'b00));

  // R11: column capture only inside a row-low period
  assert_col_in_row_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.colLatch |-> !sRas);

  // R10: the counter advances only when a counter refresh ends
  assert_adv_at_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refAdvance |-> ($past(cycleType) == CT_CBR || $past(cycleType) == CT_HIDDEN));

endmodule

// File: rtl/dcd_datapath.sv
module dcd_datapath
  import dcd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  strobe_t           strobe,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic [ADDR_W-1:0] refreshCount
);

  localparam int REFRESH_ROWS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(REFRESH_ROWS - 1);

  logic [ADDR_W-1:0] addrQ, rowReg, colReg, refCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      rowReg <= '0;
      colReg <= '0;
      refCnt <= '0;
    end else begin
      addrQ <= addr;
      if (strobe.rowLatch)   rowReg <= addrQ;
      if (strobe.colLatch)   colReg <= addrQ;
      if (strobe.refAdvance) refCnt <= (refCnt == LAST_ROW) ? '0 : refCnt + 1'b1;
    end
  end

  assign rowAddr      = strobe.useCounter ? refCnt : rowReg;
  assign colAddr      = colReg;
  assign refreshCount = refCnt;

  // R10: one step per finished refresh, wrapping
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refAdvance |=> (refCnt == ADDR_W'($past(refCnt) + 1'b1)));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.refAdvance |=> $stable(refCnt));

endmodule

// File: rtl/dcd_pulse_check.sv
module dcd_pulse_check #(
  parameter int RAS_MIN_CYC = 4,
  parameter int CAS_MIN_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lowNow,
  output logic       protoErr
);

  localparam int MAX_MIN = (RAS_MIN_CYC > CAS_MIN_CYC) ? RAS_MIN_CYC : CAS_MIN_CYC;
  localparam int CW      = $clog2(MAX_MIN + 1);

  logic [1:0] errVec;

  for (genvar g = 0; g < 2; g++) begin : gen_width
    localparam int LIM = (g == 0) ? RAS_MIN_CYC : CAS_MIN_CYC;
    localparam logic [CW-1:0] LIMV = CW'(LIM);
    logic [CW-1:0] lowCnt;

    always_ff @(posedge clk) begin
      if (!rstN)          lowCnt <= '0;
      else if (lowNow[g]) lowCnt <= (lowCnt == LIMV) ? lowCnt : lowCnt + 1'b1;
      else                lowCnt <= '0;
    end

    assign errVec[g] = !lowNow[g] && (lowCnt != '0) && (lowCnt < LIMV);

    // R9: an error only marks the end of a low pulse
    assert_err_at_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
      errVec[g] |-> (!lowNow[g] && $past(lowNow[g])));
  end

  assign protoErr = |errVec;

endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
  import dcd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int RAS_MIN_CYC = 4,
  parameter int CAS_MIN_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              lcasN,
  input  logic              ucasN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        cycleType,
  output logic [1:0]        laneDrive,
  output logic [1:0]        laneWrite,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic [ADDR_W-1:0] refreshCount,
  output logic              protoErr
);

  cycle_t     ctType;
  strobe_t    strobe;
  logic [1:0] sampledLow;

  dcd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rasN      (rasN),
    .casN      ({ucasN, lcasN}),
    .weN       (weN),
    .oeN       (oeN),
    .cycleType (ctType),
    .laneDrive (laneDrive),
    .laneWrite (laneWrite),
    .strobe    (strobe),
    .sampledLow(sampledLow)
  );

  dcd_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .strobe      (strobe),
    .rowAddr     (rowAddr),
    .colAddr     (colAddr),
    .refreshCount(refreshCount)
  );

  dcd_pulse_check #(.RAS_MIN_CYC(RAS_MIN_CYC), .CAS_MIN_CYC(CAS_MIN_CYC)) u_pulse (
    .clk     (clk),
    .rstN    (rstN),
    .lowNow  (sampledLow),
    .protoErr(protoErr)
  );

  assign cycleType = ctType;

endmodule

// File: tb/dram_cmd_decoder_test.sv
`timescale 1ns/1ps
module dram_cmd_decoder_test;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rasN = 1'b1, lcasN = 1'b1, ucasN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [2:0]    cycleType;
  logic [1:0]    laneDrive, laneWrite;
  logic [AW-1:0] rowAddr, colAddr, refreshCount;
  logic          protoErr;

  int checks = 0;
  int errors = 0;
  int expCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_cmd_decoder #(.ADDR_W(AW), .RAS_MIN_CYC(4), .CAS_MIN_CYC(2)) uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .cycleType(cycleType),
    .laneDrive(laneDrive), .laneWrite(laneWrite), .rowAddr(rowAddr),
    .colAddr(colAddr), .refreshCount(refreshCount), .protoErr(protoErr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pinsIdle();
    rasN = 1'b1; lcasN = 1'b1; ucasN = 1'b1; weN = 1'b1; oeN = 1'b1;
  endtask

  function automatic int expType(input bit we, input bit oe);
    if (!we) return 3;
    if (!oe) return 2;
    return 1;
  endfunction

  function automatic int expDrive(input bit we, input bit oe, input int lanes);
    return (we && !oe) ? lanes : 0;
  endfunction

  function automatic int expWrite(input bit we, input int lanes);
    return (!we) ? lanes : 0;
  endfunction

  task automatic access(input int row, input int col, input int lanes,
                        input bit we, input bit oe, input string req);
    addr = AW'(row); rasN = 1'b0;
    step(1);
    chk("R6", "row open type", cycleType, 1);
    step(1);
    addr = AW'(col); lcasN = !lanes[0]; ucasN = !lanes[1]; weN = we; oeN = oe;
    step(1);
    chk(req, "access type", cycleType, expType(we, oe));
    chk(req, "lane drive", laneDrive, expDrive(we, oe, lanes));
    chk(req, "lane write", laneWrite, expWrite(we, lanes));
    step(1);
    chk("R11", "column captured", colAddr, col);
    chk("R6", "row captured", rowAddr, row);
    lcasN = 1'b1; ucasN = 1'b1;
    step(1);
    chk("R9", "no error on legal column pulse", protoErr, 0);
    rasN = 1'b1;
    step(1);
    chk("R1", "standby after access", cycleType, 0);
    chk("R9", "no error on legal row pulse", protoErr, 0);
    pinsIdle();
    step(1);
  endtask

  task automatic cbrRefresh(input int lanes, input bit verbose);
    lcasN = !lanes[0]; ucasN = !lanes[1];
    step(2);
    if (verbose) begin
      chk("R5", "precharge with strobe low is standby", cycleType, 0);
      chk("R5", "precharge drive", laneDrive, 0);
    end
    rasN = 1'b0;
    step(1);
    if (verbose) begin
      chk("R5", "refresh type", cycleType, 5);
      chk("R5", "refresh hi-z", laneDrive, 0);
      chk("R5", "row from counter", rowAddr, expCnt);
    end
    step(4);
    rasN = 1'b1;
    step(2);
    expCnt = (expCnt + 1) % 1024;
    if (verbose) chk("R10", "counter advanced", refreshCount, expCnt);
    lcasN = 1'b1; ucasN = 1'b1;
    step(1);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chk("R1", "reset type", cycleType, 0);
    chk("R1", "reset drive", laneDrive, 0);
    chk("R1", "reset write", laneWrite, 0);
    chk("R1", "reset counter", refreshCount, 0);
    chk("R9", "reset error", protoErr, 0);

    // R3 / R4 directed word and byte accesses
    access(12, 34, 3, 1'b1, 1'b0, "R3");
    access(13, 35, 1, 1'b1, 1'b0, "R3");
    access(14, 36, 2, 1'b1, 1'b0, "R3");
    access(15, 37, 3, 1'b0, 1'b0, "R4");
    access(16, 38, 2, 1'b0, 1'b1, "R4");

    // R2 first fall captures, last rise ends
    addr = 10'd100; rasN = 1'b0;
    step(2);
    addr = 10'd201; lcasN = 1'b0; oeN = 1'b0;
    step(1);
    chk("R2", "lower only drive", laneDrive, 1);
    addr = 10'd302; ucasN = 1'b0;
    step(1);
    chk("R2", "both lanes drive", laneDrive, 3);
    step(1);
    chk("R2", "column from first fall", colAddr, 201);
    lcasN = 1'b1;
    step(1);
    chk("R2", "upper still active type", cycleType, 2);
    chk("R2", "upper only drive", laneDrive, 2);
    step(1);
    chk("R2", "column unchanged", colAddr, 201);
    ucasN = 1'b1;
    step(1);
    chk("R2", "last rise releases", laneDrive, 0);
    rasN = 1'b1;
    step(1);
    pinsIdle();
    step(2);

    // R11 page mode: two column periods in one row
    addr = 10'd7; rasN = 1'b0;
    step(2);
    addr = 10'd40; lcasN = 1'b0; ucasN = 1'b0; weN = 1'b0;
    step(2);
    chk("R11", "first page column", colAddr, 40);
    lcasN = 1'b1; ucasN = 1'b1; weN = 1'b1;
    step(1);
    addr = 10'd41; lcasN = 1'b0; ucasN = 1'b0; oeN = 1'b0;
    step(1);
    chk("R11", "second period reclassified read", cycleType, 2);
    step(1);
    chk("R11", "second page column", colAddr, 41);
    chk("R11", "row kept in page", rowAddr, 7);
    lcasN = 1'b1; ucasN = 1'b1;
    step(1);
    rasN = 1'b1;
    step(1);
    pinsIdle();
    step(2);

    // R8 read-modify-write
    addr = 10'd9; rasN = 1'b0;
    step(2);
    addr = 10'd50; lcasN = 1'b0; ucasN = 1'b0; oeN = 1'b0;
    step(1);
    chk("R8", "read phase", cycleType, 2);
    weN = 1'b0; oeN = 1'b1;
    step(1);
    chk("R8", "rmw type", cycleType, 4);
    chk("R8", "rmw drive off", laneDrive, 0);
    chk("R8", "rmw write lanes", laneWrite, 3);
    lcasN = 1'b1; ucasN = 1'b1;
    step(1);
    rasN = 1'b1;
    step(1);
    pinsIdle();
    step(2);

    // R5 strobe-before-row refresh, word and single byte strobe
    cbrRefresh(3, 1'b1);
    cbrRefresh(2, 1'b1);

    // R6 row-only refresh
    addr = 10'd777; rasN = 1'b0;
    step(1);
    chk("R6", "row-only open", cycleType, 1);
    step(1);
    chk("R6", "row-only row", rowAddr, 777);
    step(3);
    rasN = 1'b1;
    step(1);
    chk("R6", "row-only detected", cycleType, 7);
    chk("R6", "row-only row at end", rowAddr, 777);
    step(1);
    chk("R6", "back to standby", cycleType, 0);
    chk("R10", "row-only leaves counter", refreshCount, expCnt);
    step(1);

    // R7 hidden refresh
    addr = 10'd21; rasN = 1'b0;
    step(2);
    addr = 10'd60; lcasN = 1'b0; ucasN = 1'b0; oeN = 1'b0;
    step(2);
    rasN = 1'b1;
    step(1);
    chk("R7", "data held at row rise", laneDrive, 3);
    chk("R7", "hold type read", cycleType, 2);
    step(1);
    rasN = 1'b0;
    step(1);
    chk("R7", "hidden type", cycleType, 6);
    chk("R7", "hidden drive held", laneDrive, 3);
    chk("R7", "hidden row from counter", rowAddr, expCnt);
    step(4);
    rasN = 1'b1;
    step(1);
    chk("R7", "drive after hidden", laneDrive, 3);
    step(1);
    expCnt = (expCnt + 1) % 1024;
    chk("R10", "hidden advances counter", refreshCount, expCnt);
    lcasN = 1'b1; ucasN = 1'b1;
    step(1);
    chk("R1", "standby after hidden", cycleType, 0);
    chk("R1", "hi-z after hidden", laneDrive, 0);
    pinsIdle();
    step(2);

    // R9 short row pulse, then short column pulse
    rasN = 1'b0;
    step(2);
    rasN = 1'b1;
    step(1);
    chk("R9", "short row pulse flagged", protoErr, 1);
    step(1);
    chk("R9", "flag is one cycle", protoErr, 0);
    step(1);
    rasN = 1'b0;
    step(2);
    lcasN = 1'b0;
    step(1);
    lcasN = 1'b1;
    step(1);
    chk("R9", "short column pulse flagged", protoErr, 1);
    step(2);
    rasN = 1'b1;
    step(1);
    chk("R9", "legal row pulse not flagged", protoErr, 0);
    pinsIdle();
    step(2);

    // random byte-lane accesses
    for (int i = 0; i < 40; i++) begin
      int row = int'($urandom % 1024);
      int col = int'($urandom % 1024);
      int lanes = int'($urandom % 3) + 1;
      bit we = bit'($urandom % 2);
      bit oe = bit'($urandom % 2);
      access(row, col, lanes, we, oe, we ? "R3" : "R4");
    end

    // R10 wrap
    while (expCnt != 1023) cbrRefresh(1, 1'b0);
    chk("R10", "counter at last row", refreshCount, 1023);
    cbrRefresh(1, 1'b1);
    chk("R10", "counter wrapped", refreshCount, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule